// File: doc/BRIEF.md
# Serial Programming Enable Detector

This block is the target-side entry stage of an in-system serial programming port. It runs on the target's own clock and has no clock from the programmer: the serial clock, serial data in and the resync input are all brought in through flop synchronizers. Bits are taken from the data line on rising edges of the serial clock, most significant bit first, and grouped into four-byte instructions. The block waits for the enable instruction, whose leading two bytes must be 0xAC and then 0x53. Until it sees them, the serial data output stays undriven.

Once the two bytes match, the block raises a programming-mode flag and turns on the output enable of the serial data out pin, first driving it low. During the third byte of that instruction, it sends back 0x53 most significant bit first, changing the output on falling clock edges. During the fourth byte it drives zeros. If either byte is wrong, the block stays undriven and ignores further clock edges until the resync input has been held high. Holding that input high also leaves programming mode and restarts byte framing.

After a first successful entry, later recognitions of the enable instruction skip one synchronizer stage on the serial inputs. That shortens the lag by one target clock and allows a faster serial clock. The programmer needs to hold each serial clock phase for at least four target clocks before the first entry, and two after it.

Top module: `spi_prog_detect`

## Requirements
- R1: After power-on reset, `prog_mode` and `miso_oe` are 0 and `miso_o` is 0.
- R2: Receiving 0xAC then 0x53, MSB first on rising `sck` edges, sets `prog_mode` and `miso_oe` to 1 together, with `miso_o` at 0 in the cycle the output is first enabled.
- R3: Before any entry, `prog_mode` rises on the third `clk` rising edge that samples `sck` high on the 16th rising edge of the instruction. At the second such edge it is still 0.
- R4: A first byte other than 0xAC keeps `miso_oe` at 0 even if 0x53 follows. A complete, correct enable instruction sent afterwards without a resync pulse is also ignored.
- R5: A second byte other than 0x53 after a correct 0xAC keeps `miso_oe` at 0.
- R6: Holding `tgt_rst` high for three or more cycles clears `prog_mode` and `miso_oe` and restarts framing at bit 0. A correct enable instruction is accepted afterwards.
- R7: With `miso_oe` on, during the third byte `miso_o` presents the bits of 0x53 MSB first, each valid before the rising `sck` edge of its bit slot. During the fourth byte it is 0.
- R8: After one successful entry since power-on, a resync pulse selects the short path. `prog_mode` then rises on the second `clk` edge that samples `sck` high on the 16th rising edge, and is still 0 after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tgt_rst | input | 1 | Resync input from the programmer, active high, asynchronous to `clk` |
| sck | input | 1 | Serial clock from the programmer, asynchronous |
| mosi | input | 1 | Serial data from the programmer, asynchronous |
| prog_mode | output | 1 | Programming mode entered |
| miso_oe | output | 1 | Output enable for the serial data out pin |
| miso_o | output | 1 | Serial data out value |

## Verification
The bench counts target clocks after the final rising `sck` edge of the second byte, on both the long path and the short path. A design with one synchronizer stage too many or too few sets `prog_mode` one cycle early or late. It sends a wrong first byte and then a correct instruction without resync, to catch a design that recovers framing on its own or enables the output on the second byte alone. It samples the echo just before each rising edge of the third byte: shifting on the wrong edge, or shifting away the MSB on the falling edge at the byte boundary, gives a value other than 0x53. It also checks that a resync clears the mode and that re-entry afterwards is accepted.

// File: rtl/spd_pkg.sv
package spd_pkg;
    localparam logic [7:0] ENTRY_BYTE0 = 8'hAC;
    localparam logic [7:0] ENTRY_BYTE1 = 8'h53;
    localparam int unsigned BYTE_BITS  = 8;
endpackage

// File: rtl/spd_sync.sv
module spd_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bypass,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= d;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= stg_q[s-1];
            end
        end
    end

    // bypass drops the last stage, one cycle less lag
    assign q = bypass ? stg_q[STAGES-2] : stg_q[STAGES-1];
endmodule

// File: rtl/spd_edge.sv
module spd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    output logic rise,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sck_s;
    end

    assign rise = sck_s & ~prev_q;
    assign fall = ~sck_s & prev_q;
endmodule

// File: rtl/spd_core.sv
module spd_core #(
    parameter int unsigned INSTR_BYTES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic resync,
    input  logic rise,
    input  logic fall,
    input  logic din,
    output logic prog_mode,
    output logic out_en,
    output logic dout,
    output logic use_fast
);
    import spd_pkg::*;

    localparam int unsigned NBITS = INSTR_BYTES * BYTE_BITS;
    localparam int unsigned BCW   = $clog2(NBITS);
    localparam logic [BCW-1:0] LAST_B0  = BCW'(BYTE_BITS - 1);
    localparam logic [BCW-1:0] LAST_B1  = BCW'(2 * BYTE_BITS - 1);
    localparam logic [BCW-1:0] ECHO_BEG = BCW'(2 * BYTE_BITS);
    localparam logic [BCW-1:0] ECHO_END = BCW'(3 * BYTE_BITS);

    typedef struct packed {
        logic [BCW-1:0] bit_cnt;
        logic [7:0]     shreg;
        logic [7:0]     tx;
        logic           hdr_ok;
        logic           failed;
        logic           mode;
        logic           oe;
        logic           primed;
        logic           fast;
    } core_st_t;

    core_st_t st_d, st_q;
    logic [7:0] byte_in;

    always_comb begin
        st_d    = st_q;
        byte_in = {st_q.shreg[6:0], din};
        if (resync) begin
            st_d.bit_cnt = '0;
            st_d.shreg   = '0;
            st_d.tx      = '0;
            st_d.hdr_ok  = 1'b0;
            st_d.failed  = 1'b0;
            st_d.mode    = 1'b0;
            st_d.oe      = 1'b0;
            st_d.fast    = st_q.primed;
        end else begin
            if (rise && !st_q.failed) begin
                st_d.shreg   = byte_in;
                st_d.bit_cnt = st_q.bit_cnt + 1'b1;
                if (st_q.bit_cnt == LAST_B0) begin
                    st_d.hdr_ok = (byte_in == ENTRY_BYTE0);
                    if (byte_in != ENTRY_BYTE0 && !st_q.mode) st_d.failed = 1'b1;
                end else if (st_q.bit_cnt == LAST_B1) begin
                    if (st_q.hdr_ok && byte_in == ENTRY_BYTE1) begin
                        st_d.mode   = 1'b1;
                        st_d.oe     = 1'b1;
                        st_d.primed = 1'b1;
                        st_d.tx     = ENTRY_BYTE1;
                    end else if (!st_q.mode) begin
                        st_d.failed = 1'b1;
                    end
                end
            end
            if (fall && st_q.mode) begin
                if (st_q.bit_cnt > ECHO_BEG && st_q.bit_cnt < ECHO_END)
                    st_d.tx = {st_q.tx[6:0], 1'b0};
                else if (st_q.bit_cnt == ECHO_END)
                    st_d.tx = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prog_mode = st_q.mode;
    assign out_en    = st_q.oe;
    assign dout      = st_q.tx[7];
    assign use_fast  = st_q.fast;
endmodule

// File: rtl/spi_prog_detect.sv
module spi_prog_detect #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned INSTR_BYTES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgt_rst,
    input  logic sck,
    input  logic mosi,
    output logic prog_mode,
    output logic miso_oe,
    output logic miso_o
);
    logic [1:0] ser_s;
    logic       rst_s;
    logic       use_fast;
    logic       rise, fall;

    spd_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_ser_sync (
        .clk(clk), .rst_n(rst_n), .bypass(use_fast),
        .d({mosi, sck}), .q(ser_s)
    );

    spd_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_rst_sync (
        .clk(clk), .rst_n(rst_n), .bypass(1'b0),
        .d(tgt_rst), .q(rst_s)
    );

    spd_edge u_edge (
        .clk(clk), .rst_n(rst_n), .sck_s(ser_s[0]),
        .rise(rise), .fall(fall)
    );

    spd_core #(.INSTR_BYTES(INSTR_BYTES)) u_core (
        .clk(clk), .rst_n(rst_n), .resync(rst_s),
        .rise(rise), .fall(fall), .din(ser_s[1]),
        .prog_mode(prog_mode), .out_en(miso_oe), .dout(miso_o),
        .use_fast(use_fast)
    );
endmodule

// File: rtl/spd_checker.sv
module spd_checker (
    input logic clk,
    input logic rst_n,
    input logic tgt_rst,
    input logic prog_mode,
    input logic miso_oe,
    input logic miso_o
);
    AST_OE_FOLLOWS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe == prog_mode); // R2

    AST_FIRST_DRIVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miso_oe) |-> (prog_mode && !miso_o)); // R2

    AST_EXIT_NEEDS_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_mode) |-> $past(tgt_rst, 3)); // R6

    AST_RESYNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_rst && $past(tgt_rst) && $past(tgt_rst, 2)) |=> (!prog_mode && !miso_oe)); // R6
endmodule

bind spi_prog_detect spd_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tgt_rst(tgt_rst),
    .prog_mode(prog_mode), .miso_oe(miso_oe), .miso_o(miso_o)
);

// File: tb/spi_prog_detect_tb.sv
`timescale 1ns/1ps
module spi_prog_detect_tb;
    localparam int HP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tgt_rst = 1'b0;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic prog_mode, miso_oe, miso_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spi_prog_detect u_dut (
        .clk(clk), .rst_n(rst_n), .tgt_rst(tgt_rst), .sck(sck), .mosi(mosi),
        .prog_mode(prog_mode), .miso_oe(miso_oe), .miso_o(miso_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_resync();
        @(negedge clk);
        tgt_rst = 1'b1;
        wait_neg(6);
        tgt_rst = 1'b0;
        wait_neg(4);
    endtask

    // shifts nbits of val MSB first; returns miso seen before each rise
    task automatic send_bits(input logic [7:0] val, input int nbits, output logic [7:0] seen);
        seen = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            @(negedge clk);
            sck = 1'b0;
            mosi = val[i];
            wait_neg(HP);
            seen = {seen[6:0], miso_o};
            sck = 1'b1;
            wait_neg(HP);
        end
        @(negedge clk);
        sck = 1'b0;
    endtask

    // last bit of the second byte with cycle-exact lag check
    task automatic last_bit_lag(input bit fast, input string req);
        @(negedge clk);
        sck = 1'b0;
        mosi = 1'b1;
        wait_neg(HP);
        sck = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (fast) check({req, " mode low after first edge"}, prog_mode, 0);
        @(posedge clk);
        @(negedge clk);
        if (fast) check({req, " mode high after second edge"}, prog_mode, 1);
        else      check({req, " mode low after second edge"}, prog_mode, 0);
        @(posedge clk);
        @(negedge clk);
        check({req, " mode high by third edge"}, prog_mode, 1);
        wait_neg(HP);
    endtask

    task automatic t_power_on();
        check("R1 prog_mode", prog_mode, 0);
        check("R1 miso_oe", miso_oe, 0);
        check("R1 miso_o", miso_o, 0);
    endtask

    task automatic t_bad_first();
        logic [7:0] s;
        pulse_resync();
        send_bits(8'hAD, 8, s);
        send_bits(8'h53, 8, s);
        wait_neg(6);
        check("R4 oe after bad first byte", miso_oe, 0);
        send_bits(8'h00, 8, s);
        send_bits(8'h00, 8, s);
        send_bits(8'hAC, 8, s);
        send_bits(8'h53, 8, s);
        wait_neg(6);
        check("R4 oe after retry without resync", miso_oe, 0);
        check("R4 mode after retry without resync", prog_mode, 0);
    endtask

    task automatic t_bad_second();
        logic [7:0] s;
        pulse_resync();
        send_bits(8'hAC, 8, s);
        send_bits(8'h52, 8, s);
        wait_neg(6);
        check("R5 oe after bad second byte", miso_oe, 0);
        check("R5 mode after bad second byte", prog_mode, 0);
    endtask

    task automatic t_entry_slow();
        logic [7:0] s;
        pulse_resync();
        send_bits(8'hAC, 8, s);
        send_bits(8'h53, 7, s);
        last_bit_lag(1'b0, "R3");
        check("R2 mode", prog_mode, 1);
        check("R2 oe", miso_oe, 1);
        check("R2 first miso value", miso_o, 0);
        send_bits(8'h00, 8, s);
        check("R7 echo byte", s, 8'h53);
        send_bits(8'h00, 8, s);
        check("R7 fourth byte zeros", s, 8'h00);
    endtask

    task automatic t_resync_clears();
        logic [7:0] s;
        pulse_resync();
        check("R6 mode cleared", prog_mode, 0);
        check("R6 oe cleared", miso_oe, 0);
        send_bits(8'hAC, 8, s);
        send_bits(8'h53, 7, s);
        last_bit_lag(1'b1, "R8");
        check("R6 re-entry oe", miso_oe, 1);
        send_bits(8'h00, 8, s);
        check("R7 echo on short path", s, 8'h53);
    endtask

    initial begin
        wait_neg(5);
        rst_n = 1'b1;
        wait_neg(3);
        t_power_on();
        t_bad_first();
        t_bad_second();
        t_entry_slow();
        t_resync_clears();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule